// File: doc/BRIEF.md
# Retrying Frame Transmit Controller

This block is the transmit half of a consumer-electronics-control bus controller. Software loads a frame of up to `NBYTES` bytes (header first, then data) into a small register file, programs the frame length and a retry count, and sets a start bit. The block then drives a line-level transmitter through repeated attempts. It feeds that transmitter the frame bytes by index and takes one result code at the end of each attempt.

A negative acknowledge or a low-drive error counts as a failed attempt. The block bumps the matching saturating counter and tries again until the programmed retries are used up. An acknowledge ends the transmission successfully. Lost arbitration ends it at once. Each transmission raises exactly one of three sticky result flags, and software clears these by writing ones. The start bit reads back as 1 while the transmission runs and clears itself when the result flag is raised.

Top module: `frame_retry_tx`

## Requirements
- R1: After reset, the busy bit (bit 0 at address NBYTES+2), all status flags, both counters, the length, the retry field and `irq` read as 0.
- R2: Writing a byte with bit 0 set to address NBYTES+2 while idle starts a transmission. From then until the result, bit 0 at that address reads 1, and each attempt is announced by a one-cycle `line_start` pulse with `line_len` equal to the programmed length.
- R3: Frame bytes live at addresses 0..NBYTES-1 (header at 0). The length lives at address NBYTES. Both read back as written, and `line_rd_byte` returns the frame byte selected by `line_rd_idx`.
- R4: Writes to the frame, length or retry addresses while a transmission is active are ignored.
- R5: The retry field is bits [6:4] at address NBYTES+1. Result codes on `line_result` are 0 acknowledged, 1 not acknowledged, 2 low drive and 3 arbitration lost. Codes 1 and 2 are failures, and a transmission makes at most retry+1 attempts.
- R6: When the last allowed attempt fails, the retry-timeout flag (bit 4 of the status at NBYTES+3) is raised.
- R7: An acknowledge raises the done flag (status bit 5) and makes no further attempt.
- R8: Arbitration lost (code 3) raises status bit 3 at once, with no further attempt.
- R9: Exactly one of the three flags is raised per transmission. Writing 1 to a flag bit clears it, and `irq` is the OR of the flags.
- R10: The counter byte at NBYTES+4 holds the not-acknowledged count in bits [CW-1:0] and the low-drive count in bits [2CW-1:CW]. Both counters reset to zero when a transmission starts and saturate at 2^CW-1.
- R11: The busy bit clears in the same cycle the result flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| line_start | output | 1 | One-cycle pulse starting one attempt |
| line_len | output | $clog2(NBYTES+1) | Frame length for the attempt |
| line_rd_idx | input | $clog2(NBYTES) | Frame byte index requested by the transmitter |
| line_rd_byte | output | 8 | Frame byte at that index |
| line_done | input | 1 | Attempt finished, result valid |
| line_result | input | 2 | Attempt result code |
| irq | output | 1 | OR of the result flags |

## Verification
The bench builds the block with NBYTES=4 and CW=2. The small frame lets every byte address and every index of the line read port be covered. With 2-bit counters, saturation at 3 can be reached within the at most eight attempts that a 3-bit retry field allows. The bench sweeps every retry value from 1 to 7. For each one, it places the ending event (acknowledge or arbitration lost) at every attempt position, and also runs the case where no attempt succeeds. The failures before that point are alternating, all not-acknowledged or all low-drive. From each such run the bench computes the attempt count, the flag, and the expected saturated counters.

// File: rtl/frame_retry_tx.sv
module frame_retry_tx #(
  parameter int unsigned NBYTES = 16,
  parameter int unsigned AW = 5,
  parameter int unsigned CW = 4,
  parameter int unsigned RW = 3,
  localparam int unsigned IW = $clog2(NBYTES),
  localparam int unsigned LW = $clog2(NBYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          line_start,
  output logic [LW-1:0] line_len,
  input  logic [IW-1:0] line_rd_idx,
  output logic [7:0]    line_rd_byte,
  input  logic          line_done,
  input  logic [1:0]    line_result,
  output logic          irq
);

  localparam logic [AW-1:0] A_LEN   = AW'(NBYTES);
  localparam logic [AW-1:0] A_RETRY = AW'(NBYTES + 1);
  localparam logic [AW-1:0] A_EN    = AW'(NBYTES + 2);
  localparam logic [AW-1:0] A_STAT  = AW'(NBYTES + 3);
  localparam logic [AW-1:0] A_CNT   = AW'(NBYTES + 4);
  localparam logic [1:0] RES_ACK  = 2'd0;
  localparam logic [1:0] RES_NACK = 2'd1;
  localparam logic [1:0] RES_LOW  = 2'd2;
  localparam logic [1:0] RES_ARB  = 2'd3;
  localparam logic [CW-1:0] CMAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT} state_t;

  state_t        st;
  logic [7:0]    frame [NBYTES];
  logic [LW-1:0] len_q;
  logic [RW-1:0] retry_q, tries;
  logic [CW-1:0] nack_q, low_q;
  logic [2:0]    flags;

  logic busy, waiting, go, fin, is_fail, give_up, cfg_wr;
  logic [2:0] set_f, clr_f;

  assign busy    = st != S_IDLE;
  assign waiting = st == S_WAIT;
  assign cfg_wr  = wr_en && !busy;
  assign go      = cfg_wr && wr_addr == A_EN && wr_data[0];
  assign fin     = waiting && line_done;
  assign is_fail = fin && (line_result == RES_NACK || line_result == RES_LOW);
  assign give_up = is_fail && tries == retry_q;
  assign set_f   = {fin && line_result == RES_ACK, give_up, fin && line_result == RES_ARB};
  assign clr_f   = (wr_en && wr_addr == A_STAT) ? wr_data[5:3] : 3'b000;

  assign line_start   = st == S_LAUNCH;
  assign line_len     = len_q;
  assign line_rd_byte = frame[line_rd_idx];
  assign irq          = |flags;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tries <= '0;
    end else begin
      case (st)
        S_IDLE:   if (go) begin st <= S_LAUNCH; tries <= '0; end
        S_LAUNCH: st <= S_WAIT;
        S_WAIT:   if (fin) begin
                    if (is_fail && !give_up) begin
                      tries <= tries + 1'b1;
                      st    <= S_LAUNCH;
                    end else begin
                      st <= S_IDLE;
                    end
                  end
        default:  st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nack_q <= '0;
      low_q  <= '0;
    end else if (go) begin
      nack_q <= '0;
      low_q  <= '0;
    end else if (is_fail) begin
      if (line_result == RES_NACK && nack_q != CMAX) nack_q <= nack_q + 1'b1;
      if (line_result == RES_LOW && low_q != CMAX)   low_q  <= low_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) frame[i] <= '0;
      len_q   <= '0;
      retry_q <= '0;
    end else if (cfg_wr) begin
      if (wr_addr < A_LEN)   frame[wr_addr[IW-1:0]] <= wr_data;
      if (wr_addr == A_LEN)   len_q   <= wr_data[LW-1:0];
      if (wr_addr == A_RETRY) retry_q <= wr_data[4 +: RW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_f) | set_f;
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr < A_LEN) rd_data = frame[rd_addr[IW-1:0]];
    else begin
      case (rd_addr)
        A_LEN:   rd_data = 8'(len_q);
        A_RETRY: rd_data = 8'({retry_q, 4'b0000});
        A_EN:    rd_data = {7'b0, busy};
        A_STAT:  rd_data = {2'b00, flags, 3'b000};
        A_CNT:   rd_data = 8'({low_q, nack_q});
        default: rd_data = 8'h00;
      endcase
    end
  end

endmodule

module frame_retry_tx_chk #(
  parameter int unsigned CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          waiting,
  input logic          go,
  input logic          line_start,
  input logic          line_done,
  input logic [1:0]    line_result,
  input logic [2:0]    flags,
  input logic [CW-1:0] nack_q,
  input logic [CW-1:0] low_q
);
  localparam logic [CW-1:0] CMAX = '1;

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> busy);

  assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags & ~$past(flags)));

  assert_arb_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && line_done && line_result == 2'd3) |=> (!busy && flags[0] && !line_start));

  assert_ack_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && line_done && line_result == 2'd0) |=> (!busy && flags[2]));

  assert_clear_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (nack_q == '0 && low_q == '0));

  assert_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && nack_q == CMAX && low_q == CMAX) |=> (nack_q == CMAX && low_q == CMAX));

  assert_selfclear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[0]) || $rose(flags[1]) || $rose(flags[2])) |-> !busy);
endmodule

bind frame_retry_tx frame_retry_tx_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .waiting(waiting), .go(go),
  .line_start(line_start), .line_done(line_done), .line_result(line_result),
  .flags(flags), .nack_q(nack_q), .low_q(low_q)
);

// File: tb/frame_retry_tx_tb.sv
module frame_retry_tx_tb;
  localparam int NB = 4;
  localparam int AW = 5;
  localparam int CW = 2;
  localparam int IW = $clog2(NB);
  localparam int LW = $clog2(NB + 1);
  localparam int A_LEN = NB, A_RETRY = NB + 1, A_EN = NB + 2, A_STAT = NB + 3, A_CNT = NB + 4;
  localparam int SAT = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic line_start, line_done = 0, irq;
  logic [LW-1:0] line_len;
  logic [IW-1:0] line_rd_idx = '0;
  logic [7:0] line_rd_byte;
  logic [1:0] line_result = '0;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  frame_retry_tx #(.NBYTES(NB), .AW(AW), .CW(CW), .RW(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .line_start(line_start), .line_len(line_len),
    .line_rd_idx(line_rd_idx), .line_rd_byte(line_rd_byte), .line_done(line_done),
    .line_result(line_result), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int a, output int v);
    rd_addr = AW'(a);
    #1;
    v = int'(rd_data);
  endtask

  function automatic logic [1:0] res_of(int mode, int i, int k, int term, int r);
    if (i == k && k <= r) return term ? 2'd3 : 2'd0;
    case (mode)
      0: return (i % 2) ? 2'd2 : 2'd1;
      1: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  task automatic run(int r, int k, int term, int mode, int len, bit poke);
    int starts, guard, v, nf, ne, le, first_len;
    starts = 0; guard = 0; first_len = -1;
    wr(A_RETRY, r << 4);
    wr(A_LEN, len);
    wr(A_EN, 1);
    rd_addr = AW'(A_EN);
    #1;
    while (guard < 400) begin
      guard++;
      if (line_start) begin
        if (first_len < 0) first_len = int'(line_len);
        if (poke && starts == 0) begin
          wr_en = 1; wr_addr = AW'(0); wr_data = 8'hEE;
          @(negedge clk);
          wr_en = 1; wr_addr = AW'(A_LEN); wr_data = 8'd1;
          line_result = res_of(mode, starts, k, term, r);
          line_done = 1;
          @(negedge clk);
          wr_en = 0; line_done = 0;
        end else begin
          @(negedge clk);
          line_result = res_of(mode, starts, k, term, r);
          line_done = 1;
          @(negedge clk);
          line_done = 0;
        end
        starts++;
        rd_addr = AW'(A_EN);
        #1;
      end else begin
        if (!rd_data[0]) break;
        @(negedge clk);
        #1;
      end
    end
    if (guard >= 400) chk("R2 run hung", guard, 0);
    nf = (k <= r) ? k : r + 1;
    ne = 0; le = 0;
    for (int i = 0; i < nf; i++) begin
      if (res_of(mode, i, k, term, r) == 2'd1) ne++; else le++;
    end
    if (ne > SAT) ne = SAT;
    if (le > SAT) le = SAT;
    chk("R5 attempt count", starts, (k <= r) ? k + 1 : r + 1);
    chk("R2 line_len", first_len, len);
    rd(A_EN, v);    chk("R11 busy clears", v & 1, 0);
    rd(A_STAT, v);
    if (k > r)        chk("R6 timeout flag", v, 8'h10);
    else if (term)    chk("R8 arb flag", v, 8'h08);
    else              chk("R7 done flag", v, 8'h20);
    chk("R9 irq", int'(irq), 1);
    rd(A_CNT, v);   chk("R10 counters", v, (le << CW) | ne);
    wr(A_STAT, 8'h38);
    rd(A_STAT, v);  chk("R9 w1c clear", v, 0);
    chk("R9 irq low", int'(irq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(A_EN, v);    chk("R1 busy", v, 0);
    rd(A_STAT, v);  chk("R1 status", v, 0);
    rd(A_CNT, v);   chk("R1 counters", v, 0);
    rd(A_LEN, v);   chk("R1 length", v, 0);
    rd(A_RETRY, v); chk("R1 retry", v, 0);
    chk("R1 irq", int'(irq), 0);

    for (int i = 0; i < NB; i++) wr(i, 8'h31 * (i + 1));
    for (int i = 0; i < NB; i++) begin
      rd(i, v); chk("R3 frame readback", v, (8'h31 * (i + 1)) & 8'hFF);
      line_rd_idx = IW'(i); #1;
      chk("R3 line_rd_byte", int'(line_rd_byte), (8'h31 * (i + 1)) & 8'hFF);
    end
    wr(A_RETRY, 8'h50);
    rd(A_RETRY, v); chk("R5 retry field", v, 8'h50);

    run(2, 1, 0, 0, 3, 1'b1);
    rd(0, v);      chk("R4 frame write ignored", v, 8'h31);
    rd(A_LEN, v);  chk("R4 length write ignored", v, 3);

    for (int r = 1; r <= 7; r++)
      for (int k = 0; k <= r + 1; k++)
        for (int term = 0; term < 2; term++)
          for (int mode = 0; mode < 3; mode++)
            run(r, k, term, mode, (r + k) % (NB + 1), 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule